// File: doc/BRIEF.md
# Bus Adapter Control and Status Register Block

This block holds the software-visible control, configuration and status state of a bridge between a system bus and a peripheral bus. Software reaches it through a 32-bit register port with a write strobe, a word offset, write data and a combinational read-data return. The block runs an adapter initialization: software sets the start bit in the control register, all latched faults and error details are wiped, and after a fixed, parameterized number of clock cycles a completion flag appears in the configuration register for software to poll.

Fault and error events arrive as single-cycle pulses. Six system-bus fault classes latch into the top bits of the configuration register, and four peripheral-bus error classes latch into the status register. All of them stay set until software writes a 1 to the matching position, which lets software clear exactly what it has read by writing the same value back. Any peripheral-bus error also records the map-table index and the peripheral word address that were involved. A single interrupt line is raised while any latched fault is enabled by its group's enable bit.

Top module: `xbr_csr`

## Requirements
- R1: After reset every register reads 0 (configuration offset 0, control offset 1, status offset 2, failed map entry offset 3, failed word address offset 4) and `irq` is 0.
- R2: A write to offset 1 stores write-data bits 6..2 (bit 2 configuration-fault enable, bit 3 system-to-peripheral error enable, bit 4 peripheral-to-system error enable, bit 5 request-level enable, bit 6 interrupt pass-through), and they read back in the same positions. Control bits 1 and 31..7 read as 0.
- R3: A write to offset 1 with bit 0 set clears all fault and error latches, both error-detail registers and the completion flag, and starts the init timer. Control bit 0 reads 1 while the timer runs and 0 once it is done.
- R4: Configuration bit 16 reads 1 exactly INIT_CYCLES rising clock edges after the edge that accepted the start write. It then holds until the next start write and is not changed by writes to offset 0.
- R5: Pulse input `sysflt_pulse[i]` sets configuration bit 26+i as a sticky flag. Bit 31 is parity, 30 write sequence, 29 unexpected read, 28 interlock sequence, 27 multiple transmitter, and 26 adapter-as-transmitter.
- R6: Pulse input `perr_pulse` bits 0,1,2,3 set status bits 0 (slave-sync timeout), 3 (map parity), 4 (invalid map entry) and 5 (data path parity) as sticky flags.
- R7: Writing offset 0 or 2 clears each latched flag whose position is 1 in the write data and keeps the others. A pulse in the same cycle as such a clear leaves its flag set.
- R8: In any cycle with a nonzero `perr_pulse`, offset 3 captures `perr_map_idx` and offset 4 captures `perr_word_addr` (a word address; the byte address is 4 times it), both zero-extended. Writes to offsets 3 and 4 have no effect.
- R9: `irq` is 1 exactly when a configuration fault is latched with control bit 2 set, or status bit 0 is latched with control bit 3 set, or any of status bits 5..3 is latched with control bit 4 set. It follows the latched state one edge after a pulse or clear.
- R10: A start write wins over fault and error pulses in the same cycle, and those pulses are lost.
- R11: Offsets 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| sysflt_pulse | input | 6 | System-bus fault event pulses |
| perr_pulse | input | 4 | Peripheral-bus error event pulses |
| perr_map_idx | input | MAP_W | Map index involved in the peripheral error |
| perr_word_addr | input | UADDR_W | Peripheral word address involved in the error |
| irq | output | 1 | Interrupt request |

## Verification
Every write, pulse and capture takes effect at the next rising edge, so its result is readable on `csr_rdata` and visible on `irq` during the low phase that follows. The completion flag is the only delayed result. It is due INIT_CYCLES edges after the start write. The bench counts idle edges after that write and requires the flag to be clear one edge early and set exactly on time. All inputs are driven at the falling edge. A reference model is advanced once per rising edge, and then every offset and `irq` are compared in the next low phase, with the address swept in small delays well before the next rising edge.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned CSR_AW = 3;

    localparam logic [CSR_AW-1:0] OFS_CFG = 3'd0;
    localparam logic [CSR_AW-1:0] OFS_CTL = 3'd1;
    localparam logic [CSR_AW-1:0] OFS_STS = 3'd2;
    localparam logic [CSR_AW-1:0] OFS_FME = 3'd3;
    localparam logic [CSR_AW-1:0] OFS_FAD = 3'd4;

    localparam int unsigned NUM_SYSFLT  = 6;
    localparam int unsigned CFG_FLT_LSB = 26;
    localparam int unsigned CFG_DONE_BIT = 16;
    localparam int unsigned NUM_PERR    = 4;
    localparam int unsigned CTL_START_BIT = 0;
    localparam int unsigned CTL_IE_LSB  = 2;
    localparam int unsigned NUM_IE      = 5;

    // enable bits in the order they sit in the control word (bit 6 down to 2)
    typedef struct packed {
        logic pass_thru;
        logic req_ie;
        logic p2s_ie;
        logic s2p_ie;
        logic cfg_ie;
    } ctl_ie_t;

    // position in the status word of each peripheral error latch
    function automatic int unsigned sts_pos(input int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/xbr_init_seq.sv
module xbr_init_seq #(
    parameter int unsigned INIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.done = 1'b0;
            seq_d.cnt  = CW'(INIT_CYCLES);
        end else if (seq_q.busy) begin
            if (seq_q.cnt == CW'(1)) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.cnt  = '0;
            end else begin
                seq_d.cnt = seq_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;

    // R4: the last count step produces the completion flag
    p_done_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt == CW'(1) && !start_i) |=> done_o);
    // R4: completion flag holds until a new start
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    // R3: a running timer never shows completion
    p_busy_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
endmodule

// File: rtl/xbr_w1c_bank.sv
module xbr_w1c_bank #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all_i,
    input  logic [W-1:0] set_i,
    input  logic         w1c_en_i,
    input  logic [W-1:0] w1c_mask_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_d, lat_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            if (clr_all_i)
                lat_d[g] = 1'b0;
            else
                lat_d[g] = set_i[g] | (lat_q[g] & ~(w1c_en_i & w1c_mask_i[g]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_o = lat_q;

    // R7: a new event is never lost to a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all_i |=> (($past(set_i) & ~lat_q) == '0));
    // R10: init clear wins over everything
    p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (lat_q == '0));
    // R7: without a clear, latched bits stay
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && !w1c_en_i) |=> (($past(lat_q) & ~lat_q) == '0));
endmodule

// File: rtl/xbr_csr.sv
module xbr_csr
    import xbr_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 20,
    parameter int unsigned MAP_W       = 9,
    parameter int unsigned UADDR_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_we,
    input  logic [2:0]          csr_addr,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    input  logic [5:0]          sysflt_pulse,
    input  logic [3:0]          perr_pulse,
    input  logic [MAP_W-1:0]    perr_map_idx,
    input  logic [UADDR_W-1:0]  perr_word_addr,
    output logic                irq
);
    localparam int unsigned FME_PAD = DW - MAP_W;
    localparam int unsigned FAD_PAD = DW - UADDR_W;

    typedef struct packed {
        ctl_ie_t              ie;
        logic [MAP_W-1:0]     fme;
        logic [UADDR_W-1:0]   fad;
    } csr_state_t;

    csr_state_t st_d, st_q;

    logic                  wr_cfg, wr_ctl, wr_sts, init_start;
    logic                  init_busy, init_done;
    logic [NUM_SYSFLT-1:0] cfg_lat, cfg_mask;
    logic [NUM_PERR-1:0]   sts_lat, sts_mask;
    logic [DW-1:0]         sts_word;

    assign wr_cfg     = csr_we && (csr_addr == OFS_CFG);
    assign wr_ctl     = csr_we && (csr_addr == OFS_CTL);
    assign wr_sts     = csr_we && (csr_addr == OFS_STS);
    assign init_start = wr_ctl && csr_wdata[CTL_START_BIT];
    assign cfg_mask   = csr_wdata[CFG_FLT_LSB +: NUM_SYSFLT];

    // scatter/gather between compact status latches and status word positions
    always_comb begin
        sts_word = '0;
        for (int i = 0; i < NUM_PERR; i++) begin
            sts_mask[i]           = csr_wdata[sts_pos(i)];
            sts_word[sts_pos(i)]  = sts_lat[i];
        end
    end

    xbr_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (init_start),
        .busy_o  (init_busy),
        .done_o  (init_done)
    );

    xbr_w1c_bank #(.W(NUM_SYSFLT)) u_cfg_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (init_start),
        .set_i      (sysflt_pulse),
        .w1c_en_i   (wr_cfg),
        .w1c_mask_i (cfg_mask),
        .lat_o      (cfg_lat)
    );

    xbr_w1c_bank #(.W(NUM_PERR)) u_sts_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (init_start),
        .set_i      (perr_pulse),
        .w1c_en_i   (wr_sts),
        .w1c_mask_i (sts_mask),
        .lat_o      (sts_lat)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctl)
            st_d.ie = csr_wdata[CTL_IE_LSB +: NUM_IE];
        if (init_start) begin
            st_d.fme = '0;
            st_d.fad = '0;
        end else if (perr_pulse != '0) begin
            st_d.fme = perr_map_idx;
            st_d.fad = perr_word_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFS_CFG: begin
                csr_rdata[CFG_FLT_LSB +: NUM_SYSFLT] = cfg_lat;
                csr_rdata[CFG_DONE_BIT]              = init_done;
            end
            OFS_CTL: begin
                csr_rdata[CTL_IE_LSB +: NUM_IE] = st_q.ie;
                csr_rdata[CTL_START_BIT]        = init_busy;
            end
            OFS_STS: csr_rdata = sts_word;
            OFS_FME: csr_rdata = {{FME_PAD{1'b0}}, st_q.fme};
            OFS_FAD: csr_rdata = {{FAD_PAD{1'b0}}, st_q.fad};
            default: csr_rdata = '0;
        endcase
    end

    assign irq = ((cfg_lat != '0) && st_q.ie.cfg_ie)
              || (sts_lat[0] && st_q.ie.s2p_ie)
              || ((sts_lat[NUM_PERR-1:1] != '0) && st_q.ie.p2s_ie);

    // R3: start write wipes faults and completion
    p_init_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> (cfg_lat == '0 && sts_lat == '0 && !init_done
                        && st_q.fme == '0 && st_q.fad == '0));
    // R9: no interrupt without a latched fault
    p_irq_needs_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cfg_lat != '0 || sts_lat != '0));
    // R8: capture of error details
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_pulse != '0 && !init_start) |=>
            (st_q.fme == $past(perr_map_idx) && st_q.fad == $past(perr_word_addr)));
    // R8: detail registers hold without an error or start
    p_detail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_pulse == '0 && !init_start) |=> ($stable(st_q.fme) && $stable(st_q.fad)));
endmodule

// File: tb/xbr_csr_tb_top.sv
`timescale 1ns/100ps
module xbr_csr_tb_top;
    localparam int unsigned INIT = 20;
    localparam int unsigned MW   = 9;
    localparam int unsigned AW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [2:0]    csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic [5:0]    sysflt_pulse = '0;
    logic [3:0]    perr_pulse = '0;
    logic [MW-1:0] perr_map_idx = '0;
    logic [AW-1:0] perr_word_addr = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // reference model
    logic [5:0]    m_flt;
    logic [3:0]    m_sts;
    logic          m_done, m_busy;
    int            m_cnt;
    logic [4:0]    m_ie;
    logic [MW-1:0] m_fme;
    logic [AW-1:0] m_fad;

    always #5 clk = ~clk;

    xbr_csr #(.INIT_CYCLES(INIT), .MAP_W(MW), .UADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .sysflt_pulse(sysflt_pulse),
        .perr_pulse(perr_pulse), .perr_map_idx(perr_map_idx),
        .perr_word_addr(perr_word_addr), .irq(irq)
    );

    task automatic model_reset();
        m_flt = '0; m_sts = '0; m_done = 0; m_busy = 0; m_cnt = 0;
        m_ie = '0; m_fme = '0; m_fad = '0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                              input logic [5:0] sf, input logic [3:0] pe,
                              input logic [MW-1:0] idx, input logic [AW-1:0] wa);
        logic [5:0] cm;
        logic [3:0] sm;
        if (we && a == 3'd1 && wd[0]) begin
            m_flt = '0; m_sts = '0; m_fme = '0; m_fad = '0;
            m_done = 0; m_busy = 1; m_cnt = INIT;
        end else begin
            if (m_busy) begin
                if (m_cnt == 1) begin m_busy = 0; m_done = 1; end
                else m_cnt = m_cnt - 1;
            end
            cm = (we && a == 3'd0) ? wd[31:26] : 6'd0;
            m_flt = (m_flt & ~cm) | sf;
            sm = (we && a == 3'd2) ? {wd[5], wd[4], wd[3], wd[0]} : 4'd0;
            m_sts = (m_sts & ~sm) | pe;
            if (pe != 0) begin m_fme = idx; m_fad = wa; end
        end
        if (we && a == 3'd1) m_ie = wd[6:2];
    endtask

    function automatic logic [31:0] model_read(input int a);
        case (a)
            0: return {m_flt, 9'd0, m_done, 16'd0};
            1: return {25'd0, m_ie, 1'b0, m_busy};
            2: return {26'd0, m_sts[3], m_sts[2], m_sts[1], 2'd0, m_sts[0]};
            3: return {{(32-MW){1'b0}}, m_fme};
            4: return {{(32-AW){1'b0}}, m_fad};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic model_irq();
        return ((m_flt != 0) && m_ie[0]) || (m_sts[0] && m_ie[1]) || ((m_sts[3:1] != 0) && m_ie[2]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called in the low phase; sweeps every offset
    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            csr_addr = 3'(a);
            #0.2;
            check($sformatf("%s offset %0d", tag, a), csr_rdata, model_read(a));
        end
        check($sformatf("%s irq (R9)", tag), {31'd0, irq}, {31'd0, model_irq()});
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic [5:0] sf, input logic [3:0] pe,
                        input logic [MW-1:0] idx, input logic [AW-1:0] wa, input string tag);
        csr_we = we; csr_addr = a; csr_wdata = wd; sysflt_pulse = sf;
        perr_pulse = pe; perr_map_idx = idx; perr_word_addr = wa;
        @(posedge clk);
        model_step(we, a, wd, sf, pe, idx, wa);
        @(negedge clk);
        csr_we = 0; sysflt_pulse = '0; perr_pulse = '0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 32'd0, 6'd0, 4'd0, '0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");

        // R2 control enables and reserved bits
        step(1, 3'd1, 32'h0000_007C, 0, 0, '0, '0, "R2 enables");
        check("R2 ctl value", model_read(1), 32'h0000_007C);
        step(1, 3'd1, 32'hFFFF_FF82, 0, 0, '0, '0, "R2 reserved");
        step(1, 3'd1, 32'h0000_001C, 0, 0, '0, '0, "R2 enables");

        // R3 / R4 init handshake timing
        step(1, 3'd1, 32'h0000_001D, 0, 0, '0, '0, "R3 start");
        csr_addr = 3'd1; #0.2;
        check("R3 busy bit", csr_rdata & 32'h1, 32'h1);
        for (int k = 1; k <= INIT + 2; k++) begin
            idle("R4 wait");
            csr_addr = 3'd0; #0.2;
            check($sformatf("R4 done after %0d edges", k), (csr_rdata >> 16) & 32'h1,
                  (k >= INIT) ? 32'h1 : 32'h0);
        end

        // R5 system faults
        step(0, 3'd0, 0, 6'b100001, 0, '0, '0, "R5 faults");
        csr_addr = 3'd0; #0.2;
        check("R5 cfg bits", csr_rdata, 32'h8401_0000);
        // R6 / R8 peripheral errors with capture
        step(0, 3'd0, 0, 0, 4'b1010, 9'h1A5, 16'hBEEF, "R6 R8 errors");
        csr_addr = 3'd2; #0.2;
        check("R6 sts bits", csr_rdata, 32'h0000_0028);
        // R7 clear racing a new pulse, then plain clear; done stays
        step(1, 3'd0, 32'h8000_0000, 6'b100000, 0, '0, '0, "R7 race");
        step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, '0, '0, "R7 clear cfg");
        csr_addr = 3'd0; #0.2;
        check("R7 cfg after clear", csr_rdata, 32'h0001_0000);
        step(1, 3'd2, 32'h0000_0008, 0, 0, '0, '0, "R7 clear sts partial");
        // R8 writes to detail registers ignored, R11 unmapped
        step(1, 3'd3, 32'hFFFF_FFFF, 0, 0, '0, '0, "R8 fme write");
        step(1, 3'd4, 32'hFFFF_FFFF, 0, 0, '0, '0, "R8 fad write");
        csr_addr = 3'd4; #0.2;
        check("R8 fad held", csr_rdata, 32'h0000_BEEF);
        step(1, 3'd6, 32'hFFFF_FFFF, 0, 0, '0, '0, "R11 unmapped");
        // R9 gating
        step(1, 3'd1, 32'h0000_0000, 6'b000100, 4'b0001, 9'h3, 16'h7, "R9 masked");
        check("R9 masked irq", {31'd0, irq}, 32'd0);
        step(1, 3'd1, 32'h0000_0008, 0, 0, '0, '0, "R9 s2p enable");
        check("R9 s2p irq", {31'd0, irq}, 32'd1);
        // R10 start beats simultaneous pulses
        step(1, 3'd1, 32'h0000_001D, 6'b111111, 4'b1111, 9'h1FF, 16'hFFFF, "R10 start wins");
        csr_addr = 3'd0; #0.2;
        check("R10 cfg zero", csr_rdata, 32'd0);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic       we;
            logic [2:0] a;
            logic [31:0] wd;
            logic [5:0] sf;
            logic [3:0] pe;
            we = ($urandom % 3) == 0;
            a  = 3'($urandom % 8);
            wd = $urandom;
            if (a == 3'd1 && ($urandom % 10) != 0) wd[0] = 1'b0;
            sf = (($urandom % 6) == 0) ? 6'($urandom) : 6'd0;
            pe = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
            step(we, a, wd, sf, pe, MW'($urandom), AW'($urandom), "R5 R6 R7 R9 random");
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule